// File: doc/BRIEF.md
# Two-Bit Four-Antenna Cross-Correlator

This block correlates four baseband antenna streams against one another. Every accepted input sample is reduced to a two-bit level code by comparing its magnitude with a programmable threshold. Each antenna stream then passes through its own integer-sample delay line, so that geometric and cable delays can be compensated. For each of the six antenna pairs, the products of the delayed level codes are summed over an integration period of programmable length.

When a period ends, the six sums are copied to the output register and a one-cycle dump pulse is raised. The accumulators restart from zero with the next sample. Delay and length settings take effect only at period boundaries, so every dumped sum is built from one consistent configuration.

The control path has two named states. `ST_IDLE` is the single cycle after reset, in which the configuration is latched and input is refused. `ST_RUN` is the steady state, in which samples are accepted. There are two transitions: reset enters `ST_IDLE`, and `ST_IDLE` always moves to `ST_RUN` on the next clock. Within `ST_RUN`, each accepted sample either advances the period counter or, on the last sample of a period, closes the period and reloads the configuration.

Top module: `xcorr2b`

## Requirements
- R1: A sample is quantised to a level whose sign is the sign of the sample (zero counts as positive). Its magnitude is 3 when the absolute value is at least `quant_thr`, and 1 otherwise. Internally, the level code is {negative, large}.
- R2: Baseline k occupies `corr_sums[k*ACC_W +: ACC_W]` as a signed value. Baselines 0 to 5 are the antenna pairs (0,1), (0,2), (0,3), (1,2), (1,3) and (2,3), and each sums the product of the two levels.
- R3: With delay d (0 to DEPTH-1) set for antenna a, the correlator uses the level of the sample accepted d samples earlier on that antenna. Positions before the first sample after reset read as level +1.
- R4: `delay_cfg` and `int_len` are captured in the cycle after reset, and again with the last sample of each period. Changes made inside a period do not affect that period.
- R5: A period closes after L accepted samples, where L is the captured `int_len`; a value of 0 acts as 1. The next period starts from zero.
- R6: `dump_pulse` is high for one clock, two clock edges after the edge that accepted the last sample of a period. `corr_sums` changes only together with `dump_pulse`.
- R7: Each accumulator saturates at the largest or smallest signed ACC_W value instead of wrapping.
- R8: A sample is ignored when `in_valid` is low, and also in the first cycle after reset.
- R9: During reset, `dump_pulse` and every field of `corr_sums` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for all four antennas |
| ant_samples | input | 4*SW | Signed samples, antenna a at bits a*SW |
| quant_thr | input | SW | Magnitude threshold for the large level |
| delay_cfg | input | 4*DW | Per-antenna delay in samples, antenna a at bits a*DW |
| int_len | input | LEN_W | Samples per integration period |
| corr_sums | output | 6*ACC_W | Six signed correlation sums of the last period |
| dump_pulse | output | 1 | One-cycle flag: new sums available |

## Verification
The checker watches properties that hold on every cycle:
- the sums move only with the dump pulse;
- a dump is always preceded, two edges earlier, by an accepted sample strobe;
- the period counter stays below the captured length;
- no accumulator steps by more than one product, which rules out wrap-around.

The numerical content needs the bench's scenarios, because no single-cycle property can show it. That content covers the quantiser threshold edges, the pair ordering, the delayed-sample selection across buffer wrap, boundary-only configuration updates, zero-length handling, saturation at both extremes, and ignored strobes.

// File: rtl/xc_pkg.sv
package xc_pkg;

    localparam int NANT  = 4;
    localparam int NPAIR = NANT * (NANT - 1) / 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xc_state_t;

    // first antenna of baseline k, pairs in lexical order
    function automatic int pair_first(input int k);
        int idx;
        idx = 0;
        for (int i = 0; i < NANT; i++) begin
            for (int j = i + 1; j < NANT; j++) begin
                if (idx == k) return i;
                idx++;
            end
        end
        return 0;
    endfunction

    // second antenna of baseline k
    function automatic int pair_second(input int k);
        int idx;
        idx = 0;
        for (int i = 0; i < NANT; i++) begin
            for (int j = i + 1; j < NANT; j++) begin
                if (idx == k) return j;
                idx++;
            end
        end
        return 1;
    endfunction

endpackage

// File: rtl/xc_quant.sv
module xc_quant #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] thr,
    output logic [1:0]    code
);
    logic [SW:0] ext;
    logic [SW:0] mag;

    always_comb begin
        ext  = {sample[SW-1], sample};
        mag  = sample[SW-1] ? (~ext + 1'b1) : ext;
        code = {sample[SW-1], (mag >= {1'b0, thr})};
    end
endmodule

// File: rtl/xc_delay.sv
module xc_delay #(
    parameter int DEPTH = 256,
    parameter int DW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    code_in,
    input  logic [DW-1:0] dly,
    output logic [1:0]    code_out
);
    logic [1:0]    ring [DEPTH];
    logic [DW-1:0] wp;
    logic [DW-1:0] rp;

    always_comb begin
        rp       = wp - dly;
        code_out = (dly == '0) ? code_in : ring[rp];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            for (int i = 0; i < DEPTH; i++) ring[i] <= 2'b00;
        end else if (wr_en) begin
            ring[wp] <= code_in;
            wp       <= wp + 1'b1;
        end
    end
endmodule

// File: rtl/xc_mac.sv
module xc_mac #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic [1:0]       code_a,
    input  logic [1:0]       code_b,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] sum_out
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [4:0]       prod;
    logic [ACC_W:0]   prod_ext;
    logic [ACC_W:0]   total;
    logic [ACC_W-1:0] sat;

    always_comb begin
        logic [4:0] mag;
        if (code_a[0] && code_b[0])      mag = 5'd9;
        else if (code_a[0] || code_b[0]) mag = 5'd3;
        else                             mag = 5'd1;
        prod     = (code_a[1] ^ code_b[1]) ? (~mag + 1'b1) : mag;
        prod_ext = {{(ACC_W-4){prod[4]}}, prod};
        total    = {acc[ACC_W-1], acc} + prod_ext;
        if (total[ACC_W] != total[ACC_W-1])
            sat = total[ACC_W] ? ACC_MIN : ACC_MAX;
        else
            sat = total[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            sum_out <= '0;
        end else if (en) begin
            if (flush) begin
                sum_out <= sat;
                acc     <= '0;
            end else begin
                acc <= sat;
            end
        end
    end
endmodule

// File: rtl/xcorr2b.sv
module xcorr2b
    import xc_pkg::*;
#(
    parameter int SW    = 8,
    parameter int DEPTH = 256,
    parameter int ACC_W = 32,
    parameter int LEN_W = 24,
    parameter int DW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NANT*SW-1:0]     ant_samples,
    input  logic [SW-1:0]          quant_thr,
    input  logic [NANT*DW-1:0]     delay_cfg,
    input  logic [LEN_W-1:0]       int_len,
    output logic [NPAIR*ACC_W-1:0] corr_sums,
    output logic                   dump_pulse
);
    xc_state_t state, state_nx;

    logic [LEN_W-1:0]       act_len;
    logic [LEN_W-1:0]       cnt;
    logic [LEN_W-1:0]       cnt_top;
    logic [NANT*DW-1:0]     act_dly;
    logic                   accept;
    logic                   last_in;
    logic [1:0]             raw_code [NANT];
    logic [1:0]             dly_code [NANT];
    logic [1:0]             q_code   [NANT];
    logic                   q_vld;
    logic                   q_last;
    logic [NPAIR*ACC_W-1:0] acc_flat;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        accept  = in_valid && (state == ST_RUN);
        cnt_top = (act_len == '0) ? '0 : act_len - 1'b1;
        last_in = accept && (cnt == cnt_top);
    end

    // period counter and boundary-latched configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len <= '0;
            act_dly <= '0;
            cnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    act_len <= int_len;
                    act_dly <= delay_cfg;
                    cnt     <= '0;
                end
                ST_RUN: begin
                    if (last_in) begin
                        act_len <= int_len;
                        act_dly <= delay_cfg;
                        cnt     <= '0;
                    end else if (accept) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // per-antenna quantiser and delay line
    for (genvar a = 0; a < NANT; a++) begin : g_ant
        xc_quant #(.SW(SW)) u_quant (
            .sample (ant_samples[a*SW +: SW]),
            .thr    (quant_thr),
            .code   (raw_code[a])
        );
        xc_delay #(.DEPTH(DEPTH), .DW(DW)) u_delay (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (accept),
            .code_in  (raw_code[a]),
            .dly      (act_dly[a*DW +: DW]),
            .code_out (dly_code[a])
        );
    end

    // product stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_last <= 1'b0;
            for (int a = 0; a < NANT; a++) q_code[a] <= 2'b00;
        end else begin
            q_vld  <= accept;
            q_last <= last_in;
            if (accept)
                for (int a = 0; a < NANT; a++) q_code[a] <= dly_code[a];
        end
    end

    // one accumulator per baseline
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int PA = pair_first(k);
        localparam int PB = pair_second(k);
        xc_mac #(.ACC_W(ACC_W)) u_mac (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (q_vld),
            .flush   (q_last),
            .code_a  (q_code[PA]),
            .code_b  (q_code[PB]),
            .acc     (acc_flat[k*ACC_W +: ACC_W]),
            .sum_out (corr_sums[k*ACC_W +: ACC_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dump_pulse <= 1'b0;
        else        dump_pulse <= q_vld && q_last;
    end
endmodule

// File: rtl/xcorr2b_chk.sv
module xcorr2b_chk
    import xc_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int LEN_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   dump_pulse,
    input logic [NPAIR*ACC_W-1:0] corr_sums,
    input logic [NPAIR*ACC_W-1:0] acc_flat,
    input logic                   q_vld,
    input logic                   q_last,
    input logic [LEN_W-1:0]       cnt,
    input logic [LEN_W-1:0]       act_len,
    input xc_state_t              state
);
    // R6
    sums_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_pulse |-> $stable(corr_sums));

    // R6
    dump_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_pulse |-> $past(in_valid, 2));

    // R5
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt < ((act_len == '0) ? LEN_W'(1) : act_len)));

    for (genvar k = 0; k < NPAIR; k++) begin : g_acc
        // R7
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(q_vld && q_last) |->
                ((($signed({acc_flat[k*ACC_W+ACC_W-1], acc_flat[k*ACC_W +: ACC_W]})
                  - $signed({$past(acc_flat[k*ACC_W+ACC_W-1]), $past(acc_flat[k*ACC_W +: ACC_W])})) <= 9)
              && (($signed({acc_flat[k*ACC_W+ACC_W-1], acc_flat[k*ACC_W +: ACC_W]})
                  - $signed({$past(acc_flat[k*ACC_W+ACC_W-1]), $past(acc_flat[k*ACC_W +: ACC_W])})) >= -9)));
    end
endmodule

bind xcorr2b xcorr2b_chk #(.ACC_W(ACC_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .dump_pulse (dump_pulse),
    .corr_sums  (corr_sums),
    .acc_flat   (acc_flat),
    .q_vld      (q_vld),
    .q_last     (q_last),
    .cnt        (cnt),
    .act_len    (act_len),
    .state      (state)
);

// File: tb/xcorr2b_tb.sv
`timescale 1ns/1ps
module xcorr2b_tb;
    localparam int SW = 8, DEPTH = 256, ACC_W = 12, LEN_W = 24, DW = 8;
    localparam int AMAX = (1 << (ACC_W-1)) - 1;
    localparam int AMIN = -(1 << (ACC_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [4*SW-1:0]    ant_samples = '0;
    logic [SW-1:0]      quant_thr = '0;
    logic [4*DW-1:0]    delay_cfg = '0;
    logic [LEN_W-1:0]   int_len = '0;
    logic [6*ACC_W-1:0] corr_sums;
    logic               dump_pulse;

    always #2.5 clk = ~clk;

    xcorr2b #(.SW(SW), .DEPTH(DEPTH), .ACC_W(ACC_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ant_samples(ant_samples),
        .quant_thr(quant_thr), .delay_cfg(delay_cfg), .int_len(int_len),
        .corr_sums(corr_sums), .dump_pulse(dump_pulse)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int pa [6] = '{0, 0, 0, 1, 1, 2};
    int pb [6] = '{1, 2, 3, 2, 3, 3};

    // reference model
    int hist [4][256];
    int n_smp, m_cnt, m_len;
    int m_dly [4];
    int m_acc [6];
    int exp_sum [0:1023][6];
    string exp_tag [0:1023];
    int wr_i = 0, rd_i = 0;
    string cur_tag = "R5";
    int last_seen [6];
    bit post_dump = 0;

    function automatic int quant(input int x, input int t);
        int mag;
        mag = (x < 0) ? -x : x;
        if (x < 0) return (mag >= t) ? -3 : -1;
        return (mag >= t) ? 3 : 1;
    endfunction

    function automatic int sat(input int v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    task automatic latch_cfg();
        for (int a = 0; a < 4; a++) m_dly[a] = int'(delay_cfg[a*DW +: DW]);
        m_len = int'(int_len);
    endtask

    task automatic model_reset();
        n_smp = 0; m_cnt = 0;
        for (int k = 0; k < 6; k++) m_acc[k] = 0;
        latch_cfg();
    endtask

    task automatic model_sample(input int s0, input int s1, input int s2, input int s3);
        int s [4];
        int lv [4];
        int lim;
        s = '{s0, s1, s2, s3};
        for (int a = 0; a < 4; a++) begin
            hist[a][n_smp % 256] = quant(s[a], int'(quant_thr));
            lv[a] = (n_smp - m_dly[a] >= 0) ? hist[a][(n_smp - m_dly[a]) % 256] : 1;
        end
        for (int k = 0; k < 6; k++) m_acc[k] = sat(m_acc[k] + lv[pa[k]] * lv[pb[k]]);
        n_smp++;
        m_cnt++;
        lim = (m_len == 0) ? 1 : m_len;
        if (m_cnt >= lim) begin
            for (int k = 0; k < 6; k++) begin
                exp_sum[wr_i][k] = m_acc[k];
                m_acc[k] = 0;
            end
            exp_tag[wr_i] = cur_tag;
            wr_i++;
            m_cnt = 0;
            latch_cfg();
        end
    endtask

    task automatic push(input int s0, input int s1, input int s2, input int s3);
        @(negedge clk);
        in_valid = 1'b1;
        ant_samples = {s3[SW-1:0], s2[SW-1:0], s1[SW-1:0], s0[SW-1:0]};
        @(posedge clk);
        #0.1;
        model_sample(s0, s1, s2, s3);
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        ant_samples = $urandom;
        @(posedge clk);
    endtask

    task automatic set_dly(input int d0, input int d1, input int d2, input int d3);
        delay_cfg = {d3[DW-1:0], d2[DW-1:0], d1[DW-1:0], d0[DW-1:0]};
    endtask

    task automatic drain(input string tag);
        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (rd_i != wr_i) begin
            errors++;
            $display("FAIL %s: dumps seen %0d expected %0d", tag, rd_i, wr_i);
        end
    endtask

    // dump monitor
    always @(negedge clk) begin
        if (rst_n && dump_pulse) begin
            checks++;
            if (rd_i >= wr_i) begin
                errors++;
                $display("FAIL R5: unexpected dump, actual 1 expected 0");
            end else begin
                for (int k = 0; k < 6; k++) begin
                    if ($signed(corr_sums[k*ACC_W +: ACC_W]) != exp_sum[rd_i][k]) begin
                        errors++;
                        $display("FAIL R2 %s: period %0d baseline %0d actual %0d expected %0d",
                                 exp_tag[rd_i], rd_i, k,
                                 $signed(corr_sums[k*ACC_W +: ACC_W]), exp_sum[rd_i][k]);
                    end
                end
                rd_i++;
            end
            for (int k = 0; k < 6; k++) last_seen[k] = $signed(corr_sums[k*ACC_W +: ACC_W]);
            post_dump = 1;
        end else if (rst_n && post_dump) begin
            post_dump = 0;
            checks++;
            for (int k = 0; k < 6; k++)
                if ($signed(corr_sums[k*ACC_W +: ACC_W]) != last_seen[k]) begin
                    errors++;
                    $display("FAIL R6: sums moved without dump, actual %0d expected %0d",
                             $signed(corr_sums[k*ACC_W +: ACC_W]), last_seen[k]);
                end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        quant_thr = 8'd20;
        int_len = 1;
        set_dly(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R9 reset state
        checks++;
        if (dump_pulse !== 1'b0 || corr_sums !== '0) begin
            errors++;
            $display("FAIL R9: reset outputs actual %0h/%0b expected 0/0", corr_sums, dump_pulse);
        end
        rst_n = 1'b1;
        in_valid = 1'b1;               // R8: strobe in the idle cycle is ignored
        ant_samples = 32'h7f7f7f7f;
        @(posedge clk);
        #0.1;
        model_reset();

        // R1 quantiser edges, R2 pair order
        cur_tag = "R1 R2 R8";
        push(20, 19, -20, 0);
        push(-19, 127, -128, 1);
        push(-21, -1, 21, 100);
        drain("R1");

        // R3 R4 R5 R8 random delays, lengths and strobe gaps
        cur_tag = "R3 R4 R5 R8";
        int_len = 10;
        push(1, 1, 1, 1);
        for (int i = 0; i < 900; i++) begin
            if ($urandom_range(0, 15) == 0)
                set_dly($urandom_range(0, 255), $urandom_range(0, 255),
                        $urandom_range(0, 40), $urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) int_len = $urandom_range(1, 40);
            if ($urandom_range(0, 7) == 0) quant_thr = $urandom_range(0, 100);
            if ($urandom_range(0, 4) == 0) gap();
            push($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                 $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128);
        end
        drain("R3");

        // R4 delay change inside a period only affects the next one
        cur_tag = "R4";
        int_len = 8;
        for (int i = 0; i < 8; i++) push(i * 9 - 30, 50 - i * 11, i * 7, -i * 5);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) set_dly(5, 0, 2, 7);
            push(i * 13 - 40, 30 - i * 9, -i * 6, i * 4 - 10);
        end
        for (int i = 0; i < 8; i++) push(i * 11 - 45, i * 3, 25 - i * 8, -i * 9);
        drain("R4");

        // R5 zero length acts as one
        cur_tag = "R5";
        int_len = 0;
        for (int i = 0; i < 6; i++) push(i * 20 - 60, 40, -i * 15, 5);
        drain("R5");

        // R7 saturation at both ends, then restart from zero
        cur_tag = "R7";
        set_dly(0, 0, 0, 0);
        quant_thr = 10;
        int_len = 300;
        push(100, 100, 100, -100);
        for (int i = 0; i < 299; i++) push(100, 100, 100, -100);
        int_len = 3;
        for (int i = 0; i < 300; i++) push(100, 100, 100, -100);
        cur_tag = "R5 R7";
        for (int i = 0; i < 3; i++) push(-50, 5, 50, -5);
        drain("R7");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule